// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block sequences one programmed-I/O register access on an IDE channel. After it accepts a request, it keeps the address valid for a setup interval. It then asserts either the read or the write strobe for the command-pulse interval. It holds the address through a recovery interval, and finally pulses a completion flag. Software programs every interval length through registers outside this block. The block only selects the right fields and counts them out.

Each drive has its own timing fields. Reads and writes use separate pulse/recovery registers. The address-setup count comes from a per-drive miscellaneous register. A per-drive enhanced-mode field, taken from a register shared by all channels, can replace the programmed counts with fixed fast-mode counts. The parameter `CHAN_IDX` tells the block which channel's enhanced-mode fields belong to it.

Strobes and the address-valid flag are active-high at the block's ports. Any pad inversion happens outside the block.

Top module: `pio_cycle_timer`

## Requirements
- R1: While rst_ni is low, and afterwards until a request is accepted, addr_vld_o, rd_stb_o, wr_stb_o and done_o are all 0.
- R2: A request (req_i high while addr_vld_o is low) is accepted at a rising clock edge. For the next S+1 clocks, addr_vld_o is 1 and both strobes are 0. S is the 2-bit setup field at bits [5:4] of the selected drive's misc byte.
- R3: After setup, exactly one strobe is 1 for P+1 clocks: rd_stb_o for a read (req_wr_i=0) and wr_stb_o for a write (req_wr_i=1). P is bits [7:4] of the timing byte in use. The two strobes are never high together.
- R4: After the strobe, addr_vld_o stays 1 with both strobes 0 for R+1 clocks. R is bits [3:0] of the timing byte in use.
- R5: Reads take their timing byte from rd_tmg_i and writes from wr_tmg_i. Drive d uses byte d (bits [8d+7:8d]) of rd_tmg_i, wr_tmg_i and misc_i.
- R6: In the clock after the last recovery clock, done_o is 1 for exactly one clock, with addr_vld_o and both strobes 0.
- R7: The enhanced-mode field of drive d is emode_i[CHAN_IDX*4 + d*2 +: 2]. A value of 0 selects the programmed counts. Fields that belong to other channels have no effect.
- R8: A nonzero enhanced-mode value replaces S/P/R with fixed counts for both reads and writes: value 1 gives 1/3/2, value 2 gives 0/2/1, and value 3 gives 0/1/0.
- R9: Requests that arrive while addr_vld_o is 1 are ignored. A request held during the done_o clock is accepted at the next edge, so cycles can run back to back.
- R10: Direction, drive and all timing inputs are sampled only at acceptance. Changing them during a cycle has no effect on that cycle.
- R11: Misc bits other than [5:4] (drive index, delay value, prefetch enable) have no effect on cycle timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request |
| req_wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| req_drv_i | input | 1 | Drive select (DRV_W bits) |
| rd_tmg_i | input | 16 | Read timing byte per drive: pulse [7:4], recovery [3:0] |
| wr_tmg_i | input | 16 | Write timing byte per drive: pulse [7:4], recovery [3:0] |
| misc_i | input | 16 | Misc byte per drive; setup count at [5:4] |
| emode_i | input | 8 | Enhanced-mode fields, 2 bits per channel and drive |
| addr_vld_o | output | 1 | Address valid, high for the whole cycle |
| rd_stb_o | output | 1 | Read strobe (active high) |
| wr_stb_o | output | 1 | Write strobe (active high) |
| done_o | output | 1 | One-clock completion pulse |

## Verification
Counting from the rising edge that accepts a request as clock 0, setup occupies clocks 1 to S+1. The strobe follows for P+1 clocks, then recovery for R+1 clocks. done_o is due at clock S+P+R+4, and addr_vld_o drops in that same clock. The bench computes S, P and R from the requirements and compares all four outputs on every falling edge from clock 1 through the done clock. It also scrambles requests and settings in the middle of a cycle, and chains the next request into the done clock, so that these windows are checked rather than a single point.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned SETUP_W = 2;
  localparam int unsigned PULSE_W = 4;
  localparam int unsigned RECOV_W = 4;
  localparam int unsigned EM_W    = 2;
  localparam int unsigned CNT_W   = (PULSE_W > RECOV_W) ? PULSE_W : RECOV_W;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_RECOV
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [PULSE_W-1:0] pulse;
    logic [RECOV_W-1:0] recov;
  } cyc_tmg_t;

  // Built-in fast-mode counts, used when the enhanced field is nonzero
  function automatic cyc_tmg_t fast_tmg(input logic [EM_W-1:0] mode);
    cyc_tmg_t t;
    t = '0;
    case (mode)
      2'd1: begin t.setup = 2'd1; t.pulse = 4'd3; t.recov = 4'd2; end
      2'd2: begin t.setup = 2'd0; t.pulse = 4'd2; t.recov = 4'd1; end
      2'd3: begin t.setup = 2'd0; t.pulse = 4'd1; t.recov = 4'd0; end
      default: t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pio_tmg_select.sv
module pio_tmg_select
  import pio_tmg_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 2,
  parameter int unsigned NUM_DRV  = 2,
  parameter int unsigned CHAN_IDX = 0,
  localparam int unsigned DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
  localparam int unsigned EMODE_W = NUM_CHAN * NUM_DRV * EM_W
) (
  input  logic                     wr_i,
  input  logic [DRV_W-1:0]         drv_i,
  input  logic [NUM_DRV*REG_W-1:0] rd_tmg_i,
  input  logic [NUM_DRV*REG_W-1:0] wr_tmg_i,
  input  logic [NUM_DRV*REG_W-1:0] misc_i,
  input  logic [EMODE_W-1:0]       emode_i,
  output cyc_tmg_t                 tmg_o
);

  cyc_tmg_t drv_rd [NUM_DRV];
  cyc_tmg_t drv_wr [NUM_DRV];

  // Only misc[5:4] and this channel's mode fields matter
  logic unused_cfg;
  assign unused_cfg = ^{misc_i, emode_i};

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    logic [EM_W-1:0] mode;
    cyc_tmg_t prog_rd, prog_wr;

    assign mode = emode_i[(CHAN_IDX*NUM_DRV + d)*EM_W +: EM_W];

    assign prog_rd.setup = misc_i[d*REG_W + 4 +: SETUP_W];
    assign prog_rd.pulse = rd_tmg_i[d*REG_W + 4 +: PULSE_W];
    assign prog_rd.recov = rd_tmg_i[d*REG_W +: RECOV_W];

    assign prog_wr.setup = misc_i[d*REG_W + 4 +: SETUP_W];
    assign prog_wr.pulse = wr_tmg_i[d*REG_W + 4 +: PULSE_W];
    assign prog_wr.recov = wr_tmg_i[d*REG_W +: RECOV_W];

    assign drv_rd[d] = (mode == '0) ? prog_rd : fast_tmg(mode);
    assign drv_wr[d] = (mode == '0) ? prog_wr : fast_tmg(mode);
  end

  assign tmg_o = wr_i ? drv_wr[drv_i] : drv_rd[drv_i];

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
  import pio_tmg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic     wr_i,
  input  cyc_tmg_t tmg_i,
  output logic     addr_vld_o,
  output logic     rd_stb_o,
  output logic     wr_stb_o,
  output logic     done_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  cyc_tmg_t         tmg_q;
  logic             wr_q;
  logic             done_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tmg_q   <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (req_i) begin
          // snapshot so mid-cycle input changes do nothing
          phase_q <= PH_SETUP;
          cnt_q   <= CNT_W'(tmg_i.setup);
          tmg_q   <= tmg_i;
          wr_q    <= wr_i;
        end
        PH_SETUP: if (cnt_zero) begin
          phase_q <= PH_STROBE;
          cnt_q   <= CNT_W'(tmg_q.pulse);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: if (cnt_zero) begin
          phase_q <= PH_RECOV;
          cnt_q   <= CNT_W'(tmg_q.recov);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_RECOV: if (cnt_zero) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign addr_vld_o = (phase_q != PH_IDLE);
  assign rd_stb_o   = (phase_q == PH_STROBE) && !wr_q;
  assign wr_stb_o   = (phase_q == PH_STROBE) &&  wr_q;
  assign done_o     = done_q;

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_tmg_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 2,
  parameter int unsigned NUM_DRV  = 2,
  parameter int unsigned CHAN_IDX = 0,
  localparam int unsigned DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
  localparam int unsigned EMODE_W = NUM_CHAN * NUM_DRV * EM_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     req_wr_i,
  input  logic [DRV_W-1:0]         req_drv_i,
  input  logic [NUM_DRV*REG_W-1:0] rd_tmg_i,
  input  logic [NUM_DRV*REG_W-1:0] wr_tmg_i,
  input  logic [NUM_DRV*REG_W-1:0] misc_i,
  input  logic [EMODE_W-1:0]       emode_i,
  output logic                     addr_vld_o,
  output logic                     rd_stb_o,
  output logic                     wr_stb_o,
  output logic                     done_o
);

  cyc_tmg_t sel_tmg;

  pio_tmg_select #(
    .NUM_CHAN (NUM_CHAN),
    .NUM_DRV  (NUM_DRV),
    .CHAN_IDX (CHAN_IDX)
  ) u_sel (
    .wr_i     (req_wr_i),
    .drv_i    (req_drv_i),
    .rd_tmg_i (rd_tmg_i),
    .wr_tmg_i (wr_tmg_i),
    .misc_i   (misc_i),
    .emode_i  (emode_i),
    .tmg_o    (sel_tmg)
  );

  pio_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_i       (req_wr_i),
    .tmg_i      (sel_tmg),
    .addr_vld_o (addr_vld_o),
    .rd_stb_o   (rd_stb_o),
    .wr_stb_o   (wr_stb_o),
    .done_o     (done_o)
  );

endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic addr_vld_o,
  input logic rd_stb_o,
  input logic wr_stb_o,
  input logic done_o
);

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_o && wr_stb_o));

  a_r3_strobe_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o || wr_stb_o) |-> addr_vld_o);

  a_r2_setup_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_vld_o) |-> !(rd_stb_o || wr_stb_o));

  a_r4_recovery_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_stb_o || wr_stb_o) |-> (addr_vld_o && !done_o));

  a_r6_done_ends_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!addr_vld_o && $past(addr_vld_o)));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind pio_cycle_timer pio_cycle_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_vld_o (addr_vld_o),
  .rd_stb_o   (rd_stb_o),
  .wr_stb_o   (wr_stb_o),
  .done_o     (done_o)
);

// File: tb/tb_pio_cycle_timer.sv
module tb_pio_cycle_timer;

  localparam int CH = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic        drv = 1'b0;
  logic [15:0] rd_t = '0;
  logic [15:0] wr_t = '0;
  logic [15:0] misc = '0;
  logic [7:0]  em = '0;
  logic        addr_vld, rd_stb, wr_stb, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pio_cycle_timer #(.NUM_CHAN(2), .NUM_DRV(2), .CHAN_IDX(CH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(wr), .req_drv_i(drv),
    .rd_tmg_i(rd_t), .wr_tmg_i(wr_t), .misc_i(misc), .emode_i(em),
    .addr_vld_o(addr_vld), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .done_o(done)
  );

  // {setup[9:8], pulse[7:4], recov[3:0]} per R2..R8
  function automatic logic [9:0] exp_tmg(input logic w, input logic d,
      input logic [15:0] rv, input logic [15:0] wv, input logic [15:0] mv,
      input logic [7:0] ev);
    logic [1:0]  m;
    logic [15:0] t;
    int          b;
    b = d ? 8 : 0;
    m = ev[CH*4 + (d ? 2 : 0) +: 2];
    case (m)
      2'd1: return {2'd1, 4'd3, 4'd2};
      2'd2: return {2'd0, 4'd2, 4'd1};
      2'd3: return {2'd0, 4'd1, 4'd0};
      default: begin
        t = w ? wv : rv;
        return {mv[b+4 +: 2], t[b+4 +: 4], t[b +: 4]};
      end
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {addr,rd,wr,done} act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) begin
      req = 1'b0;
      @(negedge clk);
      chk(tag, {addr_vld, rd_stb, wr_stb, done}, 4'b0000);
    end
  endtask

  // Call right after a falling edge; request is accepted at the next rising edge
  task automatic run_cycle(input string tag, input logic w, input logic d,
      input logic [15:0] rv, input logic [15:0] wv, input logic [15:0] mv,
      input logic [7:0] ev, input bit scramble);
    logic [9:0] e;
    logic [3:0] ex;
    string      ph;
    int         s, p, r;
    wr = w; drv = d; rd_t = rv; wr_t = wv; misc = mv; em = ev; req = 1'b1;
    e = exp_tmg(w, d, rv, wv, mv, ev);
    s = int'(e[9:8]) + 1;
    p = int'(e[7:4]) + 1;
    r = int'(e[3:0]) + 1;
    @(posedge clk);
    for (int n = 1; n <= s + p + r + 1; n++) begin
      @(negedge clk);
      if (n <= s)              begin ph = "R2"; ex = 4'b1000; end
      else if (n <= s + p)     begin ph = "R3"; ex = {1'b1, !w, w, 1'b0}; end
      else if (n <= s + p + r) begin ph = "R4"; ex = 4'b1000; end
      else                     begin ph = "R6"; ex = 4'b0001; end
      chk({ph, " ", tag}, {addr_vld, rd_stb, wr_stb, done}, ex);
      if (n == s + p + r + 1) req = 1'b0;
      else if (scramble) begin
        req = 1'($urandom); wr = 1'($urandom); drv = 1'($urandom);
        rd_t = 16'($urandom); wr_t = 16'($urandom);
        misc = 16'($urandom); em = 8'($urandom);
      end else req = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'h1d3c_0a55));
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset", {addr_vld, rd_stb, wr_stb, done}, 4'b0000);
    end
    rst_n = 1'b1;
    idle(3, "R1 idle");

    run_cycle("R5 read d0", 1'b0, 1'b0, 16'h0052, 16'h00ff, 16'h0020, 8'h00, 1'b0);
    idle(2, "R6 after");
    run_cycle("R5 R11 write d1", 1'b1, 1'b1, 16'hf4c0, 16'h3107, 16'h5f8f, 8'h00, 1'b0);
    run_cycle("R2 min", 1'b0, 1'b1, 16'h0000, 16'hffff, 16'h0000, 8'h00, 1'b0);
    run_cycle("R3 max", 1'b1, 1'b0, 16'h0000, 16'h00ff, 16'h0030, 8'h00, 1'b0);
    run_cycle("R7 other chan", 1'b0, 1'b0, 16'h0023, 16'h0000, 16'h0010, 8'h0f, 1'b0);
    run_cycle("R7 other drv", 1'b0, 1'b0, 16'h0041, 16'h0000, 16'h0000, 8'hc0, 1'b0);
    run_cycle("R8 m1", 1'b0, 1'b0, 16'h00ff, 16'h00ff, 16'h0030, 8'h10, 1'b0);
    run_cycle("R8 m2", 1'b1, 1'b1, 16'hffff, 16'hffff, 16'h3030, 8'h80, 1'b0);
    run_cycle("R8 m3", 1'b1, 1'b0, 16'h00ff, 16'h00ff, 16'h0030, 8'h30, 1'b0);
    run_cycle("R9 R10 scramble", 1'b0, 1'b1, 16'h2300, 16'h0000, 16'h1000, 8'h00, 1'b1);
    run_cycle("R9 back2back", 1'b1, 1'b0, 16'h0000, 16'h0012, 16'h0000, 8'h00, 1'b1);
    idle(2, "R9 idle");

    for (int i = 0; i < 60; i++) begin
      run_cycle("R10 random", 1'($urandom), 1'($urandom), 16'($urandom),
                16'($urandom), 16'($urandom), 8'($urandom), 1'($urandom));
      if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 3)), "R9 gap");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule